// File: doc/BRIEF.md
# Drift-Corrected Nanosecond Time Counter

This block keeps a 64-bit nanosecond time value for a network timestamp unit. On every clock cycle while it runs, the value moves forward by a fixed nominal step. A drift-correction engine adds or removes a small number of nanoseconds at a programmable spacing, so software can trim the effective rate without changing the nominal step.

Software controls the block through a plain register write port. It can stop and restart the counter and load a new time while the counter is stopped. It can hold the drift engine in reset and program one packed drift word that carries the period, the step size and the sign. Software reads the time as two 32-bit halves through a read port, low half first. Reading the low half freezes a copy of the high half, so the pair stays coherent. The full 64-bit value is also driven on a port for local timestamp capture.

Both ports are control paths, not streams. A write takes effect at the clock edge that samples `wr_en`, and the write port is never stalled. A read is answered with `rd_valid` one cycle after `rd_en`. The read side has no back-pressure: the caller must accept each answer in the cycle it appears.

Top module: `tsc_drift_top`

## Requirements
- R1: After reset the counter runs from zero, the drift reset is released and the drift word is 0. Reads return 0 at the control address (bit 0 = stopped flag), at the drift-reset address and at the drift-word address.
- R2: Writing 2 to the control address (0) stops the counter and writing 4 restarts it. Any other value there has no effect. While stopped the time value holds, and control bit 0 reads 1.
- R3: Writes to the low-load (1) and high-load (2) addresses replace the low or high 32 bits of the time only while the counter is stopped. While it runs they are ignored.
- R4: While running with no drift event, the time advances by INC_NS (default 4) per clock cycle, with carry from the low half into the high half.
- R5: A read returns data with `rd_valid` one cycle after `rd_en`. The low-time address (5) returns bits 31:0 and captures bits 63:32. The high-time address (6) returns the captured copy, not the live value.
- R6: The drift word (address 4) holds the period in bits 27:0 (16 ns units), the step in bits 30:28 (0 to 7 ns) and the sign in bit 31 (1 = add). Drift events fall every period·16+8 ns of nominal time counted since the engine left reset. In the cycle of an event the step is applied together with INC_NS.
- R7: Bit 0 of the drift-reset address (3) holds the engine in reset and reads back as written. While in reset no drift event occurs and the interval phase restarts at zero.
- R8: A write to the drift word while the drift reset is clear is ignored, and the previous word stays in effect.
- R9: A step of 0 disables correction. Both a word of 0 and a word with step 0 and maximum period leave only the nominal rate.
- R10: With bit 31 clear, each drift event subtracts the step from the time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 3 | Register read address |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| time_ns | output | 64 | Live time value |

## Verification
The assertions assume the nominal step is at most 8 ns, so no clock cycle can hold two drift events. They also assume that loads reach the counter only through the stopped-state gate, and that the drift word changes only at an edge where the drift reset was held. The stimulus programs the drift word only inside a reset window and issues loads only between a stop and the next restart, with one exception: a deliberate load while running, which the bench expects to be ignored. Every timed run is bracketed by a restart write and a stop write, so the number of counting cycles, and therefore the number of drift events, is known exactly.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
  localparam int REG_AW = 3;
  localparam int DW     = 32;
  localparam int TW     = 64;

  typedef enum logic [REG_AW-1:0] {
    A_CTRL    = 3'd0,
    A_LOAD_LO = 3'd1,
    A_LOAD_HI = 3'd2,
    A_DRST    = 3'd3,
    A_DCFG    = 3'd4,
    A_TIME_LO = 3'd5,
    A_TIME_HI = 3'd6
  } reg_addr_e;

  localparam logic [DW-1:0] CMD_STOP  = 32'd2;
  localparam logic [DW-1:0] CMD_START = 32'd4;

  typedef struct packed {
    logic        add;
    logic [2:0]  step;
    logic [27:0] period;
  } drift_word_t;
endpackage

// File: rtl/tsc_regs.sv
module tsc_regs
  import tsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              run,
  output logic              drst,
  output drift_word_t       dword,
  output logic              ld_lo,
  output logic              ld_hi,
  output logic [DW-1:0]     ld_data
);
  logic        run_q, drst_q;
  drift_word_t dword_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b1;
      drst_q  <= 1'b0;
      dword_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_CTRL) begin
        if (wr_data == CMD_STOP)       run_q <= 1'b0;
        else if (wr_data == CMD_START) run_q <= 1'b1;
      end
      if (wr_addr == A_DRST) drst_q <= wr_data[0];
      if (wr_addr == A_DCFG && drst_q) dword_q <= drift_word_t'(wr_data);
    end
  end

  assign run     = run_q;
  assign drst    = drst_q;
  assign dword   = dword_q;
  assign ld_lo   = wr_en && (wr_addr == A_LOAD_LO) && !run_q;
  assign ld_hi   = wr_en && (wr_addr == A_LOAD_HI) && !run_q;
  assign ld_data = wr_data;

  // R8: the drift word moves only when the engine was held in reset
  p_word_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dword_q) |-> $past(drst_q));

  // R2: a stop command leaves the counter stopped
  p_stop_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_CTRL && wr_data == CMD_STOP) |=> !run_q);
endmodule

// File: rtl/tsc_drift.sv
module tsc_drift
  import tsc_pkg::*;
#(
  parameter int INC_NS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        run,
  input  logic        drst,
  input  drift_word_t dword,
  output logic [TW-1:0] delta
);
  localparam int AW = 33;

  logic [AW-1:0] interval, acc_q, acc_nx;
  logic          fire, ev;

  assign interval = {1'b0, dword.period, 4'b0000} + AW'(8);
  assign acc_nx   = acc_q + AW'(INC_NS);
  assign fire     = run && !drst && (acc_nx >= interval);
  assign ev       = fire && (dword.step != 3'd0);

  always_ff @(posedge clk) begin
    if (!rst_n || drst)  acc_q <= '0;
    else if (run)        acc_q <= fire ? (acc_nx - interval) : acc_nx;
  end

  always_comb begin
    delta = '0;
    if (ev) delta = dword.add ? TW'(dword.step) : (TW'(0) - TW'(dword.step));
  end

  // R6: the phase accumulator never reaches the event spacing
  p_acc_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_q < interval);

  // R7: holding the engine in reset restarts the phase
  p_phase_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drst |=> acc_q == '0);
endmodule

// File: rtl/tsc_counter.sv
module tsc_counter
  import tsc_pkg::*;
#(
  parameter int INC_NS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [DW-1:0] ld_data,
  input  logic [TW-1:0] delta,
  output logic [TW-1:0] time_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)      time_q <= '0;
    else if (ld_lo)  time_q <= {time_q[TW-1:DW], ld_data};
    else if (ld_hi)  time_q <= {ld_data, time_q[DW-1:0]};
    else if (run)    time_q <= time_q + TW'(INC_NS) + delta;
  end

  // R2: stopped counter holds its value
  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !ld_lo && !ld_hi) |=> $stable(time_q));

  // R4: nominal advance when no correction is due
  p_nominal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !ld_lo && !ld_hi && delta == '0) |=> time_q == $past(time_q) + TW'(INC_NS));
endmodule

// File: rtl/tsc_readout.sv
module tsc_readout
  import tsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  input  logic [TW-1:0]     time_q,
  input  logic              run,
  input  logic              drst,
  input  drift_word_t       dword,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] snap_q;
  logic [DW-1:0] mux;

  always_comb begin
    mux = '0;
    case (rd_addr)
      A_CTRL:    mux = {31'b0, !run};
      A_DRST:    mux = {31'b0, drst};
      A_DCFG:    mux = DW'(dword);
      A_TIME_LO: mux = time_q[DW-1:0];
      A_TIME_HI: mux = snap_q;
      default:   mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
      snap_q   <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= mux;
      if (rd_en && rd_addr == A_TIME_LO) snap_q <= time_q[TW-1:DW];
    end
  end

  // R5: every read is answered exactly one cycle later
  p_answer_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R5: low read captures the high half of the same instant
  p_snapshot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_addr == A_TIME_LO) |=> snap_q == $past(time_q[TW-1:DW]));
endmodule

// File: rtl/tsc_drift_top.sv
module tsc_drift_top
  import tsc_pkg::*;
#(
  parameter int INC_NS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  input  logic [REG_AW-1:0] rd_addr,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  output logic [TW-1:0]     time_ns
);
  logic          run, drst, ld_lo, ld_hi;
  logic [DW-1:0] ld_data;
  logic [TW-1:0] delta;
  drift_word_t   dword;

  tsc_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .run(run), .drst(drst), .dword(dword), .ld_lo(ld_lo), .ld_hi(ld_hi), .ld_data(ld_data)
  );

  tsc_drift #(.INC_NS(INC_NS)) u_drift (
    .clk(clk), .rst_n(rst_n), .run(run), .drst(drst), .dword(dword), .delta(delta)
  );

  tsc_counter #(.INC_NS(INC_NS)) u_counter (
    .clk(clk), .rst_n(rst_n), .run(run), .ld_lo(ld_lo), .ld_hi(ld_hi),
    .ld_data(ld_data), .delta(delta), .time_q(time_ns)
  );

  tsc_readout u_readout (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .time_q(time_ns),
    .run(run), .drst(drst), .dword(dword), .rd_valid(rd_valid), .rd_data(rd_data)
  );
endmodule

// File: tb/tsc_drift_top_tb.sv
`timescale 1ns/1ps
module tsc_drift_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic [63:0] time_ns;

  int total = 0;
  int fails = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  tsc_drift_top u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data), .time_ns(time_ns)
  );

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  // monitor: pops the expected answer for every returned read
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      total++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL unexpected read data actual=%h expected=none", rd_data);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rd_data !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, rd_data, e);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [2:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // load while stopped, then run for w+2 counting cycles and stop again
  task automatic timed_run(input logic [31:0] lo, input logic [31:0] hi, input int w);
    wr(3'd1, lo);
    wr(3'd2, hi);
    wr(3'd0, 32'd4);
    idle(w);
    wr(3'd0, 32'd2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state
    rd_exp(3'd0, 32'd0, "R1 control after reset");
    rd_exp(3'd3, 32'd0, "R1 drift reset after reset");
    rd_exp(3'd4, 32'd0, "R1 drift word after reset");

    // R2 stop, frozen value, ignored command
    wr(3'd0, 32'd2);
    rd_exp(3'd0, 32'd1, "R2 stopped flag");
    wr(3'd1, 32'd100);
    wr(3'd2, 32'd0);
    rd_exp(3'd5, 32'd100, "R3 low load while stopped");
    idle(5);
    rd_exp(3'd5, 32'd100, "R2 time holds while stopped");
    wr(3'd0, 32'd1);
    rd_exp(3'd0, 32'd1, "R2 other command ignored");

    // R3 load while running ignored: 4 counting cycles
    wr(3'd0, 32'd4);
    wr(3'd2, 32'h55);
    wr(3'd0, 32'd2);
    rd_exp(3'd5, 32'd116, "R4 nominal advance");
    rd_exp(3'd6, 32'd0, "R3 high load ignored while running");

    // R4 carry into the high half: 2 counting cycles
    timed_run(32'hFFFF_FFF8, 32'd2, 0);
    rd_exp(3'd5, 32'd0, "R4 carry low half");
    rd_exp(3'd6, 32'd3, "R4 carry high half");

    // R5 snapshot coherence
    wr(3'd1, 32'h11);
    wr(3'd2, 32'h22);
    rd_exp(3'd5, 32'h11, "R5 low read");
    wr(3'd2, 32'h99);
    rd_exp(3'd6, 32'h22, "R5 high read returns snapshot");
    rd_exp(3'd5, 32'h11, "R5 low read again");
    rd_exp(3'd6, 32'h99, "R5 new snapshot");

    // R8 word write without reset is ignored
    wr(3'd4, 32'hB000_0000);
    rd_exp(3'd4, 32'd0, "R8 drift word unchanged");

    // R7 engine held in reset: 12 cycles, no events
    wr(3'd3, 32'd1);
    rd_exp(3'd3, 32'd1, "R7 drift reset reads back");
    wr(3'd4, 32'hB000_0000);
    rd_exp(3'd4, 32'hB000_0000, "R6 drift word accepted in reset");
    timed_run(32'd1000, 32'd0, 10);
    rd_exp(3'd5, 32'd1048, "R7 no drift while in reset");

    // R6 add 3 ns every 8 ns: 12 cycles, 6 events
    wr(3'd3, 32'd0);
    rd_exp(3'd3, 32'd0, "R7 drift reset released");
    timed_run(32'd1000, 32'd0, 10);
    rd_exp(3'd5, 32'd1066, "R6 add correction");
    rd_exp(3'd6, 32'd0, "R6 high half");

    // R10 subtract 5 ns every 24 ns: 30 cycles, 5 events
    wr(3'd3, 32'd1);
    wr(3'd4, 32'h5000_0001);
    wr(3'd3, 32'd0);
    timed_run(32'd5000, 32'd0, 28);
    rd_exp(3'd5, 32'd5095, "R10 subtract correction");

    // R9 zero step with maximum period
    wr(3'd3, 32'd1);
    wr(3'd4, 32'h0FFF_FFFF);
    wr(3'd3, 32'd0);
    timed_run(32'd2000, 32'd0, 10);
    rd_exp(3'd5, 32'd2048, "R9 zero step max period");

    // R9 all-zero word
    wr(3'd3, 32'd1);
    wr(3'd4, 32'd0);
    wr(3'd3, 32'd0);
    timed_run(32'd3000, 32'd0, 10);
    rd_exp(3'd5, 32'd3048, "R9 zero word");

    idle(4);
    if (exp_q.size() != 0) begin
      total++; fails++;
      $display("FAIL reads missing actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule